// File: doc/BRIEF.md
# Cell Input Router

This block sits on the receive side of a cell-switching device. It takes fixed-length cells from one input stream and steers each cell to one or more of four output queues. The input word is 9 bits in narrow mode, which is one byte per beat, or 18 bits in wide mode, which is two bytes per beat. The cell length is a byte count that software programs. The router decides the destination on the first word of each cell. It holds that decision until the last word, and it counts beats to find the end of the cell.

The destination set can come from three places: the address bus, a routing field in the first data word, or a programmed multicast mask. The address bus also carries a device field, which must equal the programmed chip identifier before the cell is kept. This lets several routers share one wide input bus. The queues report whether they have room for a whole cell. The router refuses a new cell until every queue it would write has that room. A start-of-cell that arrives before the current cell ends is reported as an error. The queues are told to discard the partial cell, and the new cell starts.

The input is a valid/ready stream. A beat transfers on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` depends only on `in_sop`, the routing inputs, the configuration and `q_space`, never on `in_valid`. It can drop only on a beat that starts a cell. Once a beat with `in_sop` is presented, the source must hold it until it is accepted. The queue side has no back-pressure during a cell, because space was checked when the cell was admitted. Configuration is written through a plain write strobe with a 2-bit register select.

Top module: `cell_router`

## Requirements
- R1: Writing select 0 (`cfg_sel`=0) sets the cell length in bytes, clamped to the range 16 to 128; the reset value is 16. A cell lasts the programmed number of beats in narrow mode and half of it, rounded up, in wide mode. `q_eoc` is high with the write of the final beat.
- R2: Bit 2 of select 2 chooses the width: 1 selects wide, 0 selects narrow. In narrow mode `q_data[8:0]` equals `in_data[8:0]` and `q_data[17:9]` is zero. In wide mode all 18 bits pass through.
- R3: Bits [1:0] of select 2 give the routing mode. In mode 0 (out-band unicast) the queue index is `in_addr[1:0]`. In every mode `in_addr[4:2]` must equal the chip identifier, which is written at select 1, bits [2:0].
- R4: In mode 2 (in-band mask), bit i of `in_data[3:0]` in the first word of the cell selects queue i.
- R5: In mode 3 (in-band unicast), the queue index is `in_data[1:0]` of the first word of the cell.
- R6: In mode 1 (out-band multicast), the mask written at select 3, bits [3:0], picks the queues. Every selected queue is strobed in the same cycle with the same data.
- R7: A cell whose device field does not match, or whose selection is empty, is consumed with `in_ready` high. It produces no `q_wr`, `q_sop` or `q_eoc`.
- R8: On a start-of-cell beat, `in_ready` is low unless `q_space` is high for every selected queue. Nothing is written while the beat is held.
- R9: The destination set and the width are latched on the first beat. Later changes to the address, the data or the configuration during the cell do not alter where the rest of the cell goes.
- R10: A start-of-cell accepted before the current cell ends pulses `sop_err` for one cycle. It also drives `q_abort` with the old cell's destination set, and the same beat begins the new cell.
- R11: `in_ready` is high for every beat without `in_sop`. Beats without `in_sop` outside a cell are dropped.
- R12: An accepted beat appears on the queue outputs one cycle later. `q_sop` marks the first written word of a cell.
- R13: After reset, `q_wr`, `q_sop`, `q_eoc`, `q_abort` and `sop_err` are zero. The configuration is length 16, chip identifier 0, mode 0, narrow width and mask 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Router can take the beat |
| in_sop | input | 1 | Beat is the first word of a cell |
| in_addr | input | 5 | Device field [4:2] and queue index [1:0] |
| in_data | input | 18 | Input word; bits [8:0] only in narrow mode |
| q_space | input | 4 | Per queue: room for one whole cell |
| q_wr | output | 4 | Per-queue write strobe |
| q_data | output | 18 | Word written to the strobed queues |
| q_sop | output | 1 | Written word is the first of a cell |
| q_eoc | output | 1 | Written word is the last of a cell |
| q_abort | output | 4 | Per queue: discard the partial cell |
| sop_err | output | 1 | Start-of-cell arrived mid-cell |

## Verification
The bench targets cells cut short by an early start-of-cell. A router that ignores this would run the old beat count across the new cell and misplace `q_eoc`, or would abort the wrong queues. Length writes outside the 16-to-128 range and odd lengths in wide mode check the clamp and the rounding; an off-by-one counter shows up as a moved `q_eoc`. Back-pressure is tested with one queue in a multicast set missing space. A router that checked only some of the set would write into a full queue. Configuration writes during a cell, and changes to the address and data there, catch a design that recomputes the destination on every beat instead of latching it.

// File: rtl/cell_router_pkg.sv
package cell_router_pkg;

  typedef enum logic [1:0] {
    RM_OUT_UNI = 2'd0,
    RM_OUT_MC  = 2'd1,
    RM_IN_MASK = 2'd2,
    RM_IN_UNI  = 2'd3
  } route_mode_e;

  localparam logic [1:0] CFG_LEN  = 2'd0;
  localparam logic [1:0] CFG_ID   = 2'd1;
  localparam logic [1:0] CFG_MODE = 2'd2;
  localparam logic [1:0] CFG_MASK = 2'd3;

endpackage

// File: rtl/cr_cfg_regs.sv
module cr_cfg_regs
  import cell_router_pkg::*;
#(
  parameter int NQ      = 4,
  parameter int ID_W    = 3,
  parameter int LEN_W   = 8,
  parameter int CFG_W   = 8,
  parameter int MIN_LEN = 16,
  parameter int MAX_LEN = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [LEN_W-1:0]  cell_len,
  output logic [ID_W-1:0]   chip_id,
  output route_mode_e       mode,
  output logic              wide,
  output logic [NQ-1:0]     mc_mask
);

  localparam logic [CFG_W-1:0] MIN_C = CFG_W'(MIN_LEN);
  localparam logic [CFG_W-1:0] MAX_C = CFG_W'(MAX_LEN);

  // clamp the requested byte count into the legal window
  logic [CFG_W-1:0] len_clamped;
  always_comb begin
    if (cfg_wdata < MIN_C)      len_clamped = MIN_C;
    else if (cfg_wdata > MAX_C) len_clamped = MAX_C;
    else                        len_clamped = cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_len <= LEN_W'(MIN_LEN);
      chip_id  <= '0;
      mode     <= RM_OUT_UNI;
      wide     <= 1'b0;
      mc_mask  <= NQ'(1);
    end else if (cfg_we) begin
      unique case (cfg_sel)
        CFG_LEN:  cell_len <= LEN_W'(len_clamped);
        CFG_ID:   chip_id  <= cfg_wdata[ID_W-1:0];
        CFG_MODE: begin
          mode <= route_mode_e'(cfg_wdata[1:0]);
          wide <= cfg_wdata[2];
        end
        CFG_MASK: mc_mask  <= cfg_wdata[NQ-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cr_route_sel.sv
module cr_route_sel
  import cell_router_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int ADDR_W = 5,
  parameter int QB     = $clog2(NQ),
  parameter int ID_W   = ADDR_W - QB
) (
  input  route_mode_e        mode,
  input  logic [ID_W-1:0]    chip_id,
  input  logic [NQ-1:0]      mc_mask,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NQ-1:0]      route_word,
  output logic [NQ-1:0]      dest,
  output logic               hit
);

  always_comb begin
    hit  = (addr[ADDR_W-1:QB] == chip_id);
    dest = '0;
    unique case (mode)
      RM_OUT_UNI: dest[addr[QB-1:0]]       = 1'b1;
      RM_OUT_MC:  dest                     = mc_mask;
      RM_IN_MASK: dest                     = route_word;
      RM_IN_UNI:  dest[route_word[QB-1:0]] = 1'b1;
      default:    dest                     = '0;
    endcase
  end

endmodule

// File: rtl/cr_cell_ctr.sv
module cr_cell_ctr #(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [LEN_W-1:0]  beats,
  output logic              in_cell,
  output logic              last
);

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] beats_q;

  // a continuation beat closes the cell when it is beat number beats_q-1
  assign last = step && (cnt == beats_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cell <= 1'b0;
      cnt     <= '0;
      beats_q <= '0;
    end else if (start) begin
      in_cell <= 1'b1;
      cnt     <= LEN_W'(1);
      beats_q <= beats;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      if (last) in_cell <= 1'b0;
    end
  end

endmodule

// File: rtl/cell_router.sv
module cell_router
  import cell_router_pkg::*;
#(
  parameter int NQ      = 4,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 18,
  parameter int LEN_W   = 8,
  parameter int MIN_LEN = 16,
  parameter int MAX_LEN = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NQ-1:0]     q_space,
  output logic [NQ-1:0]     q_wr,
  output logic [DATA_W-1:0] q_data,
  output logic              q_sop,
  output logic              q_eoc,
  output logic [NQ-1:0]     q_abort,
  output logic              sop_err
);

  localparam int QB     = $clog2(NQ);
  localparam int ID_W   = ADDR_W - QB;
  localparam int BYTE_W = DATA_W / 2;

  logic [LEN_W-1:0] cfg_len;
  logic [ID_W-1:0]  cfg_id;
  route_mode_e      cfg_mode;
  logic             cfg_wide;
  logic [NQ-1:0]    cfg_mask;

  cr_cfg_regs #(
    .NQ(NQ), .ID_W(ID_W), .LEN_W(LEN_W), .CFG_W(8),
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cell_len(cfg_len), .chip_id(cfg_id),
    .mode(cfg_mode), .wide(cfg_wide), .mc_mask(cfg_mask)
  );

  logic [NQ-1:0] sel_dest;
  logic          sel_hit;

  cr_route_sel #(.NQ(NQ), .ADDR_W(ADDR_W), .QB(QB), .ID_W(ID_W)) u_sel (
    .mode(cfg_mode), .chip_id(cfg_id), .mc_mask(cfg_mask),
    .addr(in_addr), .route_word(in_data[NQ-1:0]),
    .dest(sel_dest), .hit(sel_hit)
  );

  logic keep;
  logic space_ok;
  logic fire;
  logic start;
  logic step;
  logic err;
  logic in_cell;
  logic last;
  logic [LEN_W:0]   len_p1;
  logic [LEN_W-1:0] beats;

  assign keep     = sel_hit && (sel_dest != '0);
  assign space_ok = &(q_space | ~sel_dest);

  // admission: only a start-of-cell beat may be held back
  always_comb begin
    if (in_sop) in_ready = keep ? space_ok : 1'b1;
    else        in_ready = 1'b1;
  end

  assign fire  = in_valid && in_ready;
  assign start = fire && in_sop;
  assign step  = fire && !in_sop && in_cell;
  assign err   = start && in_cell;

  assign len_p1 = {1'b0, cfg_len} + 1'b1;
  assign beats  = cfg_wide ? len_p1[LEN_W:1] : cfg_len;

  cr_cell_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .beats(beats), .in_cell(in_cell), .last(last)
  );

  // per-cell latched routing
  logic [NQ-1:0] cur_dest;
  logic          cell_wide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_dest  <= '0;
      cell_wide <= 1'b0;
    end else if (start) begin
      cur_dest  <= keep ? sel_dest : '0;
      cell_wide <= cfg_wide;
    end
  end

  logic [NQ-1:0]     wr_now;
  logic              wide_now;
  logic [DATA_W-1:0] data_now;

  always_comb begin
    if (start)     wr_now = keep ? sel_dest : '0;
    else if (step) wr_now = cur_dest;
    else           wr_now = '0;
    wide_now = start ? cfg_wide : cell_wide;
    data_now = wide_now ? in_data
                        : {{(DATA_W-BYTE_W){1'b0}}, in_data[BYTE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_wr    <= '0;
      q_data  <= '0;
      q_sop   <= 1'b0;
      q_eoc   <= 1'b0;
      q_abort <= '0;
      sop_err <= 1'b0;
    end else begin
      q_wr    <= wr_now;
      q_data  <= data_now;
      q_sop   <= start && keep;
      q_eoc   <= last && (cur_dest != '0);
      q_abort <= err ? cur_dest : '0;
      sop_err <= err;
    end
  end

endmodule

// File: rtl/cell_router_chk.sv
module cell_router_chk #(
  parameter int NQ     = 4,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sop,
  input logic              in_cell,
  input logic              cell_wide,
  input logic [NQ-1:0]     q_space,
  input logic [NQ-1:0]     q_wr,
  input logic [DATA_W-1:0] q_data,
  input logic              q_sop,
  input logic              q_eoc,
  input logic [NQ-1:0]     q_abort,
  input logic              sop_err
);

  localparam int BYTE_W = DATA_W / 2;

  a_r12_write_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (q_wr != '0) |-> $past(in_valid && in_ready));

  a_r8_space_at_admission: assert property (@(posedge clk) disable iff (!rst_n)
    q_sop |-> ((q_wr & ~$past(q_space)) == '0));

  a_r11_ready_mid_cell: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cell && !in_sop) |-> in_ready);

  a_r10_err_from_early_sop: assert property (@(posedge clk) disable iff (!rst_n)
    sop_err |-> $past(in_valid && in_ready && in_sop && in_cell));

  a_r10_abort_only_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (q_abort != '0) |-> sop_err);

  a_r1_eoc_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    q_eoc |-> (q_wr != '0));

  a_r2_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_wr != '0) && !q_sop && !cell_wide) |-> (q_data[DATA_W-1:BYTE_W] == '0));

endmodule

bind cell_router cell_router_chk #(.NQ(NQ), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sop(in_sop), .in_cell(in_cell), .cell_wide(cell_wide),
  .q_space(q_space), .q_wr(q_wr), .q_data(q_data), .q_sop(q_sop),
  .q_eoc(q_eoc), .q_abort(q_abort), .sop_err(sop_err)
);

// File: tb/sim_cell_router.sv
module sim_cell_router;

  localparam int NQ = 4;
  localparam int SB = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sop = 1'b0;
  logic [4:0]  in_addr = '0;
  logic [17:0] in_data = '0;
  logic [3:0]  q_space = 4'hF;
  logic [3:0]  q_wr;
  logic [17:0] q_data;
  logic        q_sop;
  logic        q_eoc;
  logic [3:0]  q_abort;
  logic        sop_err;

  always #4 clk = ~clk;

  cell_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_addr(in_addr), .in_data(in_data),
    .q_space(q_space), .q_wr(q_wr), .q_data(q_data), .q_sop(q_sop),
    .q_eoc(q_eoc), .q_abort(q_abort), .sop_err(sop_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected stream per queue: {sop, eoc, data}
  logic [19:0] sb [NQ][SB];
  int wp [NQ];
  int rp [NQ];

  // model of the configuration
  int         b_len = 16;
  logic [2:0] b_id = 3'd0;
  int         b_mode = 0;
  bit         b_wide = 1'b0;
  logic [3:0] b_mask = 4'b0001;
  bit         b_in_cell = 1'b0;
  logic [3:0] b_cur = '0;

  function automatic logic [3:0] f_dest(int mode, logic [4:0] a, logic [17:0] d, logic [3:0] m);
    logic [3:0] r = '0;
    case (mode)
      0: r[a[1:0]] = 1'b1;
      1: r = m;
      2: r = d[3:0];
      default: r[d[1:0]] = 1'b1;
    endcase
    return r;
  endfunction

  function automatic int f_beats();
    return b_wide ? (b_len + 1) / 2 : b_len;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int q = 0; q < NQ; q++) begin
        if (q_wr[q]) begin
          if (rp[q] == wp[q]) begin
            chk(1'b0, "R7 write to queue with nothing expected", q, 99);
          end else begin
            logic [19:0] got = {q_sop, q_eoc, q_data};
            logic [19:0] exp = sb[q][rp[q] % SB];
            chk(got == exp, "R1 R2 R12 queue word", got, exp);
            rp[q]++;
          end
        end
      end
    end
  end

  // tasks begin and end at a falling edge
  task automatic cfg_write(int sel, int val);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      0: b_len = (val < 16) ? 16 : (val > 128) ? 128 : val;
      1: b_id = 3'(val);
      2: begin b_mode = val & 3; b_wide = val[2]; end
      default: b_mask = 4'(val);
    endcase
  endtask

  task automatic beat(bit sop, logic [4:0] a, logic [17:0] d, bit exp_rdy, string req);
    in_valid = 1'b1; in_sop = sop; in_addr = a; in_data = d;
    #1 chk(in_ready == exp_rdy, req, in_ready, exp_rdy);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_cell(logic [4:0] a, logic [17:0] d0, int cut, bit midcfg);
    logic [3:0] dst = f_dest(b_mode, a, d0, b_mask);
    bit keep = (a[4:2] == b_id) && (dst != 0);
    int n = f_beats();
    int nb = (cut > 0) ? cut : n;
    bit exp_err = b_in_cell;
    logic [3:0] old = b_cur;
    for (int i = 0; i < nb; i++) begin
      logic [17:0] d = (i == 0) ? d0 : 18'($urandom);
      logic [4:0] aa = (i == 0) ? a : 5'($urandom);
      logic [17:0] dm = b_wide ? d : {9'd0, d[8:0]};
      if (i == 1 && midcfg) begin
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = {4'd0, ~b_mask};
      end
      beat(i == 0, aa, d, 1'b1, "R11 R7 ready for beat");
      if (i == 1 && midcfg) begin
        cfg_we = 1'b0; b_mask = ~b_mask;
      end
      if (i == 0) begin
        chk(sop_err == exp_err, "R10 sop_err", sop_err, exp_err);
        chk(q_abort == (exp_err ? old : 4'd0), "R10 q_abort", q_abort, exp_err ? old : 4'd0);
      end
      if (keep) begin
        for (int q = 0; q < NQ; q++) begin
          if (dst[q]) begin
            sb[q][wp[q] % SB] = {i == 0, i == n - 1, dm};
            wp[q]++;
          end
        end
      end
    end
    b_in_cell = (nb < n);
    b_cur = keep ? dst : 4'd0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int q = 0; q < NQ; q++) begin wp[q] = 0; rp[q] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(q_wr == 0, "R13 q_wr after reset", q_wr, 0);
    chk(q_sop == 0 && q_eoc == 0, "R13 sop/eoc after reset", {q_sop, q_eoc}, 0);
    chk(q_abort == 0 && sop_err == 0, "R13 abort after reset", {q_abort, sop_err}, 0);
    chk(in_ready == 1'b1, "R13 ready after reset", in_ready, 1);
    @(negedge clk);

    // R13 defaults: length 16, id 0, mode 0 narrow; R3 each queue
    for (int q = 0; q < NQ; q++) send_cell({3'd0, 2'(q)}, 18'h3_FFFF, 0, 0);

    // R11 stray words outside a cell
    for (int i = 0; i < 3; i++) beat(1'b0, 5'd0, 18'(i + 7), 1'b1, "R11 stray word ready");
    chk(q_wr == 0, "R11 stray word not written", q_wr, 0);

    // R1 clamp low and high, wide mode with odd length
    cfg_write(0, 5);
    send_cell(5'd1, 18'h1_2345, 0, 0);
    cfg_write(2, 4);
    cfg_write(0, 200);
    send_cell(5'd2, 18'h2_ABCD, 0, 0);
    cfg_write(0, 17);
    send_cell(5'd3, 18'h3_0F0F, 0, 0);

    // R7 chip mismatch
    cfg_write(1, 5);
    send_cell({3'd2, 2'd0}, 18'h1, 0, 0);
    chk(q_wr == 0, "R7 mismatch no write", q_wr, 0);
    send_cell({3'd5, 2'd2}, 18'h2, 0, 0);

    // R4 in-band mask, empty mask dropped
    cfg_write(2, 2);
    cfg_write(0, 16);
    send_cell({3'd5, 2'd0}, 18'h0_0A5, 0, 0);
    send_cell({3'd5, 2'd3}, 18'h0_0F0, 0, 0);
    // R5 in-band unicast
    cfg_write(2, 3);
    send_cell({3'd5, 2'd0}, 18'h0_0C2, 0, 0);

    // R6 multicast, R9 mask rewritten mid-cell
    cfg_write(2, 1);
    cfg_write(3, 11);
    send_cell({3'd5, 2'd0}, 18'h0_155, 0, 1);
    send_cell({3'd5, 2'd0}, 18'h0_0AA, 0, 0);

    // R8 back-pressure: queue 2 of mask 0100 lacks space
    q_space = 4'b1011;
    in_valid = 1'b1; in_sop = 1'b1; in_addr = {3'd5, 2'd0}; in_data = 18'h33;
    for (int i = 0; i < 3; i++) begin
      #1 chk(in_ready == 1'b0, "R8 ready held low", in_ready, 0);
      @(posedge clk); #1;
      chk(q_wr == 0, "R8 no write while held", q_wr, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    q_space = 4'hF;
    send_cell({3'd5, 2'd0}, 18'h33, 0, 0);

    // R10 early start-of-cell
    cfg_write(2, 0);
    send_cell({3'd5, 2'd1}, 18'h44, 5, 0);
    send_cell({3'd5, 2'd3}, 18'h55, 0, 0);

    // constrained random cells
    for (int k = 0; k < 40; k++) begin
      int r = $urandom_range(0, 3);
      if (r == 0) cfg_write(2, $urandom_range(0, 7));
      if (r == 1) cfg_write(0, $urandom_range(16, 40));
      if (r == 2) cfg_write(3, $urandom_range(0, 15));
      if (k % 13 == 5) cfg_write(1, $urandom_range(0, 7));
      begin
        logic [2:0] dev = ($urandom_range(0, 4) == 0) ? 3'($urandom) : b_id;
        int n = f_beats();
        int cut = ($urandom_range(0, 7) == 0) ? $urandom_range(1, n - 1) : 0;
        bit mc = (cut == 0) && ($urandom_range(0, 4) == 0);
        send_cell({dev, 2'($urandom)}, 18'($urandom), cut, mc);
      end
    end

    repeat (3) @(negedge clk);
    for (int q = 0; q < NQ; q++)
      chk(rp[q] == wp[q], "R6 all expected writes seen", rp[q], wp[q]);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule